// File: doc/BRIEF.md
# Nonvolatile Write Guard with Lockable Protection Register

This block decides, one request at a time, whether a byte write into a 16K x 8 nonvolatile array may go ahead. It also holds the protection register that controls that decision. The register is reached at the very top of the 16-bit address space. A write request to that address changes the register and never touches the array.

Three independent controls combine in the decision. A software enable latch must be set before any array byte can be written. A two-bit lock level shields the whole array, its upper half, its upper quarter, or none of it. A permanent-lock flag only takes effect while the external write-protect pin is high. It then turns the locked region into read-only memory and also freezes the protection register itself.

The surrounding controller presents the address, the data and the request strobe for one clock cycle. It reads back a registered grant one cycle later and uses it to start, or to skip, the programming cycle.

Top module: `eeprom_wr_guard`

## Requirements
- R1: After synchronous reset, `wr_permit` is 0 and `prot_reg` is 8'h00.
- R2: A request to an array address (0000h–3FFFh) is refused while the enable latch (`prot_reg` bit 1) is 0.
- R3: A register write (address FFFFh) with data exactly 8'h02 sets the enable latch. A register write with data bit 1 equal to 0 clears it.
- R4: In `prot_reg`, only bit 1 (enable), bits 4:3 (lock level) and bit 7 (permanent lock) can be 1. Every other bit always reads 0.
- R5: A register write while the enable latch is 0 leaves bits 7, 4 and 3 unchanged.
- R6: The lock level selects the refused array range: 00 none, 01 3000h–3FFFh, 10 2000h–3FFFh, 11 the whole array. An unlocked array address with the latch set is granted.
- R7: `wr_permit` follows a request by exactly one clock and is 0 in the cycle after any cycle without a request. A request issued the cycle after a register write is judged against the updated register.
- R8: A request to any address from 4000h to FFFEh is refused and leaves `prot_reg` unchanged.
- R9: When bit 7 is 1 and `wp_pin` is 1, register writes are refused and leave `prot_reg` unchanged, and locked array addresses are refused. Unlocked array addresses are still granted when the latch is set.
- R10: With `wp_pin` at 0, bit 7 has no effect and the register stays writable under the enable rules.
- R11: A register write that is not frozen by R9 is granted (`wr_permit` = 1), even when it leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | One-cycle write request strobe |
| wr_addr | input | 16 | Byte address of the request |
| wr_data | input | 8 | Data byte; used only when the address is FFFFh |
| wp_pin | input | 1 | Hardware write-protect pin, active high |
| wr_permit | output | 1 | Registered grant for the previous cycle's request |
| prot_reg | output | 8 | Current protection register contents |

## Verification
The main function is exercised first with array writes at both edges of every lock range: 2FFFh against 3000h and 1FFFh against 2000h. These separate the quarter and half decodes from an off-by-one boundary. Register writes are sent with the enable latch clear and then set, and with data that sets all bits. This distinguishes the one-byte enable sequence, the latch-gated lock update, and the masking of unused bits. The same register and array writes are repeated with the write-protect pin low and then high after the permanent flag is set, which isolates the pin qualification. Back-to-back requests and idle cycles confirm that each grant follows a request by exactly one clock and reflects the register as just updated.

// File: rtl/eeg_pkg.sv
`timescale 1ns/1ps
package eeg_pkg;
  // Field positions inside the protection register
  localparam int WEL_POS  = 1;
  localparam int BL_LO    = 3;
  localparam int BL_HI    = 4;
  localparam int WPEN_POS = 7;

  // Lock level encoding, ordered by growing protected range
  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_e;

  // Request target after address decode
  typedef enum logic [1:0] {
    TGT_ARRAY = 2'b00,
    TGT_REG   = 2'b01,
    TGT_VOID  = 2'b10
  } tgt_e;
endpackage

// File: rtl/eeg_addr_class.sv
`timescale 1ns/1ps
module eeg_addr_class #(
  parameter int ADDR_W   = 16,
  parameter int ARRAY_AW = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output eeg_pkg::tgt_e     tgt,
  output logic [1:0]        blk
);
  import eeg_pkg::*;

  localparam int HI_W = ADDR_W - ARRAY_AW;

  logic in_array;
  logic at_top;

  // Address inside the array window when all bits above it are zero
  assign in_array = (addr[ADDR_W-1:ARRAY_AW] == {HI_W{1'b0}});
  // Register sits at the all-ones address
  assign at_top   = &addr;
  // Top two array address bits pick the quarter
  assign blk      = addr[ARRAY_AW-1:ARRAY_AW-2];

  always_comb begin
    if (in_array)    tgt = TGT_ARRAY;
    else if (at_top) tgt = TGT_REG;
    else             tgt = TGT_VOID;
  end
endmodule

// File: rtl/eeg_lock_dec.sv
`timescale 1ns/1ps
module eeg_lock_dec (
  input  eeg_pkg::lock_e lvl,
  input  logic [1:0]     blk,
  output logic           locked
);
  import eeg_pkg::*;

  // Each level protects the upper part of the array
  always_comb begin
    unique case (lvl)
      LOCK_NONE: locked = 1'b0;
      LOCK_QTR:  locked = (blk == 2'b11);
      LOCK_HALF: locked = blk[1];
      default:   locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeg_prot_reg.sv
`timescale 1ns/1ps
module eeg_prot_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  input  logic              wp_pin,
  output logic [DATA_W-1:0] q,
  output logic              wel,
  output eeg_pkg::lock_e    lvl,
  output logic              frozen
);
  import eeg_pkg::*;

  localparam logic [DATA_W-1:0] WEL_ONLY = DATA_W'(1) << WEL_POS;

  logic       wel_q;
  logic [1:0] bl_q;
  logic       wpen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      bl_q   <= 2'b00;
      wpen_q <= 1'b0;
    end else if (upd) begin
      // Enable latch: set by the exact enable byte, cleared by bit 1 low
      if (din == WEL_ONLY)
        wel_q <= 1'b1;
      else if (!din[WEL_POS])
        wel_q <= 1'b0;
      // Lock fields move only when the latch was already set
      if (wel_q) begin
        bl_q   <= din[BL_HI:BL_LO];
        wpen_q <= din[WPEN_POS];
      end
    end
  end

  always_comb begin
    q              = '0;
    q[WEL_POS]     = wel_q;
    q[BL_HI:BL_LO] = bl_q;
    q[WPEN_POS]    = wpen_q;
  end

  assign wel    = wel_q;
  assign lvl    = lock_e'(bl_q);
  assign frozen = wpen_q & wp_pin;
endmodule

// File: rtl/eeprom_wr_guard.sv
`timescale 1ns/1ps
module eeprom_wr_guard #(
  parameter int ADDR_W   = 16,
  parameter int ARRAY_AW = 14,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_pin,
  output logic              wr_permit,
  output logic [DATA_W-1:0] prot_reg
);
  import eeg_pkg::*;

  tgt_e       tgt;
  logic [1:0] blk;
  lock_e      lvl;
  logic       wel;
  logic       frozen;
  logic       locked;
  logic       reg_upd;
  logic       grant_c;
  logic       permit_q;

  eeg_addr_class #(
    .ADDR_W   (ADDR_W),
    .ARRAY_AW (ARRAY_AW)
  ) u_class (
    .addr (wr_addr),
    .tgt  (tgt),
    .blk  (blk)
  );

  eeg_lock_dec u_lock (
    .lvl    (lvl),
    .blk    (blk),
    .locked (locked)
  );

  assign reg_upd = wr_req && (tgt == TGT_REG) && !frozen;

  eeg_prot_reg #(
    .DATA_W (DATA_W)
  ) u_preg (
    .clk    (clk),
    .rst    (rst),
    .upd    (reg_upd),
    .din    (wr_data),
    .wp_pin (wp_pin),
    .q      (prot_reg),
    .wel    (wel),
    .lvl    (lvl),
    .frozen (frozen)
  );

  always_comb begin
    grant_c = 1'b0;
    if (wr_req) begin
      unique case (tgt)
        TGT_ARRAY: grant_c = wel && !locked;
        TGT_REG:   grant_c = !frozen;
        default:   grant_c = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) permit_q <= 1'b0;
    else     permit_q <= grant_c;
  end

  assign wr_permit = permit_q;
endmodule

// File: rtl/eeg_guard_chk.sv
`timescale 1ns/1ps
module eeg_guard_chk #(
  parameter int ADDR_W   = 16,
  parameter int ARRAY_AW = 14,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wp_pin,
  input logic              wr_permit,
  input logic [DATA_W-1:0] prot_reg
);
  import eeg_pkg::*;

  localparam logic [DATA_W-1:0] USED =
    (DATA_W'(1) << WEL_POS) | (DATA_W'(3) << BL_LO) | (DATA_W'(1) << WPEN_POS);

  logic is_arr, is_reg, is_void;
  assign is_arr  = (wr_addr[ADDR_W-1:ARRAY_AW] == '0);
  assign is_reg  = &wr_addr;
  assign is_void = !is_arr && !is_reg;

  AST_IDLE_NO_PERMIT: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> !wr_permit); // R7

  AST_ARRAY_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    (wr_req && is_arr && !prot_reg[WEL_POS]) |=> !wr_permit); // R2

  AST_VOID_DENY: assert property (@(posedge clk) disable iff (rst)
    (wr_req && is_void) |=> !wr_permit); // R8

  AST_VOID_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && is_void) |=> $stable(prot_reg)); // R8

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (prot_reg & ~USED) == '0); // R4

  AST_FULL_LOCK_DENY: assert property (@(posedge clk) disable iff (rst)
    (wr_req && is_arr && prot_reg[BL_HI:BL_LO] == 2'b11) |=> !wr_permit); // R6

  AST_FROZEN_REG_DENY: assert property (@(posedge clk) disable iff (rst)
    (wr_req && is_reg && prot_reg[WPEN_POS] && wp_pin) |=> !wr_permit); // R9

  AST_FROZEN_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && is_reg && prot_reg[WPEN_POS] && wp_pin) |=> $stable(prot_reg)); // R9

  AST_LOCK_FIELDS_NEED_WEL: assert property (@(posedge clk) disable iff (rst)
    (wr_req && is_reg && !prot_reg[WEL_POS])
      |=> ($stable(prot_reg[WPEN_POS]) && $stable(prot_reg[BL_HI:BL_LO]))); // R5
endmodule

bind eeprom_wr_guard eeg_guard_chk #(
  .ADDR_W   (ADDR_W),
  .ARRAY_AW (ARRAY_AW),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_req    (wr_req),
  .wr_addr   (wr_addr),
  .wp_pin    (wp_pin),
  .wr_permit (wr_permit),
  .prot_reg  (prot_reg)
);

// File: tb/sim_eeprom_wr_guard.sv
`timescale 1ns/1ps
module sim_eeprom_wr_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wp_pin = 1'b0;
  logic        wr_permit;
  logic [7:0]  prot_reg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       permit;
    logic [7:0] regv;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  eeprom_wr_guard u0 (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wp_pin    (wp_pin),
    .wr_permit (wr_permit),
    .prot_reg  (prot_reg)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Driver: one request per cycle, expected result pushed to the scoreboard
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic w,
                    input logic ep, input logic [7:0] er, input string tag);
    @(negedge clk);
    wr_req  = 1'b1;
    wr_addr = a;
    wr_data = d;
    wp_pin  = w;
    sb.push_back('{ep, er, tag});
  endtask

  task automatic idle(input logic [7:0] er, input string tag);
    @(negedge clk);
    wr_req = 1'b0;
    sb.push_back('{1'b0, er, tag});
  endtask

  // Monitor: result of the previous cycle's request is visible after the edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({7'b0, wr_permit}, {7'b0, e.permit}, {e.tag, " permit"});
        check(prot_reg, e.regv, {e.tag, " register"});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({7'b0, wr_permit}, 8'h00, "R1 reset permit");
    check(prot_reg, 8'h00, "R1 reset register");
    rst = 1'b0;

    wr(16'h0000, 8'h55, 0, 0, 8'h00, "R2 array with latch clear");
    wr(16'hFFFF, 8'h9A, 0, 1, 8'h00, "R5 R11 reg write latch clear");
    wr(16'hFFFF, 8'h02, 0, 1, 8'h02, "R3 enable byte");
    wr(16'h0000, 8'h11, 0, 1, 8'h02, "R6 no lock low addr");
    wr(16'h3FFF, 8'h11, 0, 1, 8'h02, "R6 no lock top addr");
    wr(16'h4000, 8'h11, 0, 0, 8'h02, "R8 first void addr");
    wr(16'hFFFE, 8'hFF, 0, 0, 8'h02, "R8 last void addr");
    wr(16'hFFFF, 8'hFF, 0, 1, 8'h9A, "R4 all ones masked");
    wr(16'h0000, 8'h11, 0, 0, 8'h9A, "R6 full lock");
    wr(16'hFFFF, 8'h0A, 0, 1, 8'h0A, "R10 pin low reg writable");
    wr(16'h2FFF, 8'h11, 0, 1, 8'h0A, "R6 quarter below");
    wr(16'h3000, 8'h11, 0, 0, 8'h0A, "R6 quarter edge");
    wr(16'hFFFF, 8'h12, 0, 1, 8'h12, "R6 set half");
    wr(16'h1FFF, 8'h11, 0, 1, 8'h12, "R6 half below");
    wr(16'h2000, 8'h11, 0, 0, 8'h12, "R6 half edge");
    wr(16'hFFFF, 8'h8A, 0, 1, 8'h8A, "R10 set permanent with pin low");
    wr(16'hFFFF, 8'h00, 1, 0, 8'h8A, "R9 frozen register");
    wr(16'h3000, 8'h11, 1, 0, 8'h8A, "R9 locked in rom mode");
    wr(16'h0100, 8'h11, 1, 1, 8'h8A, "R9 unlocked in rom mode");
    wr(16'hFFFF, 8'h88, 0, 1, 8'h88, "R3 clear latch lock kept");
    wr(16'h0100, 8'h11, 0, 0, 8'h88, "R2 latch cleared");
    wr(16'hFFFF, 8'h00, 0, 1, 8'h88, "R5 lock fields held");
    idle(8'h88, "R7 idle cycle");
    wr(16'hFFFF, 8'h02, 0, 1, 8'h8A, "R3 re-enable");
    wr(16'h0100, 8'h11, 0, 1, 8'h8A, "R7 back to back");
    idle(8'h8A, "R7 trailing idle");
    idle(8'h8A, "R7 final idle");

    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule